// File: doc/BRIEF.md
# Serial Tool Entry Security Gate

This block runs once after a synchronous reset and decides how a target device's serial tool port is allowed to start. It watches a byte stream from a serial receiver (a data byte plus a one-cycle valid strobe). The first byte picks a line mode or asks for debug access. A three-byte setup frame follows, made of a command byte, a baud code and a supply voltage in tenths of a volt. A nonvolatile debug-enable bit decides whether a debug request may proceed.

Any rejection sends one status byte through a ready/valid transmitter port and then parks the block in a lock state that only reset leaves. An unknown first byte parks it at once, without a reply. A fully accepted setup raises a sticky session-granted output. The registered outputs (tool-mode code, debug-request flag, baud selection, wide-voltage flag) are meant to configure the logic that runs the later programming or debug protocol.

Top module: `serial_entry_gate`

## Requirements
- R1: After reset, tool_mode is 0x00, dbg_req, baud_sel, wide_volt, granted and tx_valid are all 0.
- R2: A first byte of 0x3A loads tool_mode with 0x3A and leaves dbg_req at 0.
- R3: A first byte of 0x00 loads tool_mode with 0x35 and leaves dbg_req at 0.
- R4: A first byte of 0xC5 sets dbg_req to 1 and leaves tool_mode at 0x00.
- R5: Any other first byte locks the block at once with no status reply. It never grants afterwards and its outputs keep their reset values.
- R6: The three bytes after the first are command, baud code and voltage, in that order. A command other than 0x9A replies status 0x04, then locks, and leaves baud_sel at 0.
- R7: With command 0x9A, a baud code of 4 or more replies 0x05 and locks. A baud code below 4 is ORed into baud_sel, even when the voltage check then fails.
- R8: A voltage byte below 18 replies 0x05 and locks, and wide_volt stays 0.
- R9: When the frame passes but dbg_req is 1 and dbg_enable is 0, the block replies 0x10 and locks, and tool_mode, dbg_req and baud_sel keep their values.
- R10: A frame that passes every check, with no blocked debug request, raises granted on the cycle after the voltage byte, and granted stays high until reset.
- R11: A status reply appears as tx_valid one cycle after the voltage byte. tx_data stays stable until tx_ready is seen, and tx_valid drops on the cycle after acceptance.
- R12: While locked, received bytes change no output.
- R13: When a frame passes, wide_volt takes the value of low_speed sampled in the cycle the voltage byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| tx_data | output | 8 | Status byte to send |
| tx_valid | output | 1 | Status byte offered |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| dbg_enable | input | 1 | Nonvolatile debug-permit bit (1 = permitted) |
| low_speed | input | 1 | Low-speed operating mode selected |
| tool_mode | output | 8 | Tool-mode code (0x00, 0x3A or 0x35) |
| dbg_req | output | 1 | Debug entry was requested |
| baud_sel | output | BAUD_W | Accumulated baud selection |
| wide_volt | output | 1 | Wide-voltage mode |
| granted | output | 1 | Session granted |

## Verification
The bench builds the gate with its default parameters: a 2-bit baud field, baud limit 4 and voltage floor 18. These are small enough to sweep all 256 first bytes and every combination of entry byte, command, baud codes 0 to 5, voltages either side of the floor, both debug-enable values and both speed settings. The sweep reaches every rejection path in its order of priority. It also covers the baud value that is kept through a later voltage failure, and the protect error with debug either permitted or blocked. Transmitter stalls of zero to two cycles check that the reply is held, and a byte sent after every lock checks that the lock state is absorbing.

// File: rtl/serial_entry_gate_pkg.sv
package serial_entry_gate_pkg;

    localparam logic [7:0] FIRST_ONE_WIRE = 8'h3A;
    localparam logic [7:0] FIRST_TWO_WIRE = 8'h00;
    localparam logic [7:0] FIRST_DEBUG    = 8'hC5;

    localparam logic [7:0] MODE_NONE      = 8'h00;
    localparam logic [7:0] MODE_ONE_WIRE  = 8'h3A;
    localparam logic [7:0] MODE_TWO_WIRE  = 8'h35;

    localparam logic [7:0] CMD_SET_BAUD   = 8'h9A;

    localparam logic [7:0] STS_BAD_CMD    = 8'h04;
    localparam logic [7:0] STS_BAD_PARAM  = 8'h05;
    localparam logic [7:0] STS_PROTECT    = 8'h10;

    typedef enum logic [2:0] {
        GS_FIRST,
        GS_CMD,
        GS_BAUD,
        GS_VOLT,
        GS_REPLY,
        GS_GRANT,
        GS_LOCK
    } gate_state_e;

    typedef enum logic [1:0] {
        ENTRY_ONE_WIRE,
        ENTRY_TWO_WIRE,
        ENTRY_DEBUG,
        ENTRY_REJECT
    } entry_kind_e;

    typedef struct packed {
        entry_kind_e kind;
        logic        load_mode;
        logic [7:0]  mode_code;
        logic        set_dbg;
    } entry_dec_t;

    typedef enum logic [1:0] {
        VERD_ACCEPT,
        VERD_BAD_CMD,
        VERD_BAD_BAUD,
        VERD_BAD_VOLT
    } verdict_e;

    typedef struct packed {
        verdict_e verdict;
        logic     apply_baud;
        logic     accept;
    } frame_res_t;

    function automatic entry_dec_t decode_first(input logic [7:0] b);
        entry_dec_t d;
        d.kind      = ENTRY_REJECT;
        d.load_mode = 1'b0;
        d.mode_code = MODE_NONE;
        d.set_dbg   = 1'b0;
        case (b)
            FIRST_ONE_WIRE: begin
                d.kind      = ENTRY_ONE_WIRE;
                d.load_mode = 1'b1;
                d.mode_code = MODE_ONE_WIRE;
            end
            FIRST_TWO_WIRE: begin
                d.kind      = ENTRY_TWO_WIRE;
                d.load_mode = 1'b1;
                d.mode_code = MODE_TWO_WIRE;
            end
            FIRST_DEBUG: begin
                d.kind    = ENTRY_DEBUG;
                d.set_dbg = 1'b1;
            end
            default: d.kind = ENTRY_REJECT;
        endcase
        return d;
    endfunction

    function automatic logic [7:0] verdict_status(input verdict_e v);
        logic [7:0] s;
        case (v)
            VERD_BAD_CMD:  s = STS_BAD_CMD;
            VERD_BAD_BAUD: s = STS_BAD_PARAM;
            VERD_BAD_VOLT: s = STS_BAD_PARAM;
            default:       s = STS_PROTECT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_entry_decode.sv
module seg_entry_decode
    import serial_entry_gate_pkg::*;
(
    input  logic [7:0] first_byte,
    output entry_dec_t dec
);
    always_comb dec = decode_first(first_byte);
endmodule

// File: rtl/seg_frame_check.sv
module seg_frame_check
    import serial_entry_gate_pkg::*;
#(
    parameter int BAUD_LIMIT = 4,
    parameter int VOLT_MIN   = 18
) (
    input  logic [7:0] cmd_byte,
    input  logic [7:0] baud_byte,
    input  logic [7:0] volt_byte,
    output frame_res_t res
);
    localparam logic [7:0] BAUD_LIM_B = 8'(BAUD_LIMIT);
    localparam logic [7:0] VOLT_MIN_B = 8'(VOLT_MIN);

    logic cmd_ok;
    logic baud_ok;
    logic volt_ok;

    always_comb begin
        cmd_ok  = (cmd_byte == CMD_SET_BAUD);
        baud_ok = (baud_byte < BAUD_LIM_B);
        volt_ok = (volt_byte >= VOLT_MIN_B);

        res.apply_baud = cmd_ok && baud_ok;
        res.accept     = cmd_ok && baud_ok && volt_ok;
        if (!cmd_ok)
            res.verdict = VERD_BAD_CMD;
        else if (!baud_ok)
            res.verdict = VERD_BAD_BAUD;
        else if (!volt_ok)
            res.verdict = VERD_BAD_VOLT;
        else
            res.verdict = VERD_ACCEPT;
    end
endmodule

// File: rtl/seg_reply_port.sv
module seg_reply_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] code,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              sent
);
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            data_q  <= code;
        end else if (valid_q && tx_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign tx_valid = valid_q;
    assign tx_data  = data_q;
    assign sent     = valid_q && tx_ready;
endmodule

// File: rtl/serial_entry_gate.sv
module serial_entry_gate
    import serial_entry_gate_pkg::*;
#(
    parameter int BAUD_W     = 2,
    parameter int BAUD_LIMIT = 4,
    parameter int VOLT_MIN   = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              dbg_enable,
    input  logic              low_speed,
    output logic [7:0]        tool_mode,
    output logic              dbg_req,
    output logic [BAUD_W-1:0] baud_sel,
    output logic              wide_volt,
    output logic              granted
);
    gate_state_e       state_q;
    logic [7:0]        cmd_q;
    logic [7:0]        baud_q;
    logic [7:0]        tool_q;
    logic              dbg_q;
    logic [BAUD_W-1:0] baud_sel_q;
    logic              wide_q;

    entry_dec_t entry;
    frame_res_t frame;
    logic       debug_blocked;
    logic       reply_load;
    logic [7:0] reply_code;
    logic       reply_sent;

    seg_entry_decode u_entry (
        .first_byte (rx_data),
        .dec        (entry)
    );

    seg_frame_check #(
        .BAUD_LIMIT (BAUD_LIMIT),
        .VOLT_MIN   (VOLT_MIN)
    ) u_frame (
        .cmd_byte  (cmd_q),
        .baud_byte (baud_q),
        .volt_byte (rx_data),
        .res       (frame)
    );

    always_comb begin
        debug_blocked = dbg_q && !dbg_enable;
        reply_load    = (state_q == GS_VOLT) && rx_valid &&
                        (!frame.accept || debug_blocked);
        reply_code    = frame.accept ? STS_PROTECT : verdict_status(frame.verdict);
    end

    seg_reply_port #(
        .DATA_W (8)
    ) u_reply (
        .clk      (clk),
        .rst      (rst),
        .load     (reply_load),
        .code     (reply_code),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .sent     (reply_sent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= GS_FIRST;
            cmd_q      <= '0;
            baud_q     <= '0;
            tool_q     <= MODE_NONE;
            dbg_q      <= 1'b0;
            baud_sel_q <= '0;
            wide_q     <= 1'b0;
        end else begin
            case (state_q)
                GS_FIRST: if (rx_valid) begin
                    if (entry.kind == ENTRY_REJECT) begin
                        state_q <= GS_LOCK;
                    end else begin
                        if (entry.load_mode) tool_q <= entry.mode_code;
                        if (entry.set_dbg)   dbg_q  <= 1'b1;
                        state_q <= GS_CMD;
                    end
                end
                GS_CMD: if (rx_valid) begin
                    cmd_q   <= rx_data;
                    state_q <= GS_BAUD;
                end
                GS_BAUD: if (rx_valid) begin
                    baud_q  <= rx_data;
                    state_q <= GS_VOLT;
                end
                GS_VOLT: if (rx_valid) begin
                    if (frame.apply_baud)
                        baud_sel_q <= baud_sel_q | baud_q[BAUD_W-1:0];
                    if (frame.accept) begin
                        wide_q  <= low_speed;
                        state_q <= debug_blocked ? GS_REPLY : GS_GRANT;
                    end else begin
                        state_q <= GS_REPLY;
                    end
                end
                GS_REPLY: if (reply_sent) state_q <= GS_LOCK;
                GS_GRANT: state_q <= GS_GRANT;
                GS_LOCK:  state_q <= GS_LOCK;
                default:  state_q <= GS_LOCK;
            endcase
        end
    end

    assign tool_mode = tool_q;
    assign dbg_req   = dbg_q;
    assign baud_sel  = baud_sel_q;
    assign wide_volt = wide_q;
    assign granted   = (state_q == GS_GRANT);
endmodule

// File: rtl/serial_entry_gate_chk.sv
module serial_entry_gate_chk
    import serial_entry_gate_pkg::*;
#(
    parameter int BAUD_W = 2
) (
    input logic              clk,
    input logic              rst,
    input gate_state_e       state,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic [7:0]        tool_mode,
    input logic              dbg_req,
    input logic [BAUD_W-1:0] baud_sel,
    input logic              wide_volt,
    input logic              granted,
    input logic              dbg_enable
);
    // R11: an offered reply is held with the same byte until taken
    p_reply_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R6: only the three defined status codes are ever offered
    p_reply_code_r6: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_data == 8'h04 || tx_data == 8'h05 || tx_data == 8'h10));

    // R5: lock is absorbing
    p_lock_absorb_r5: assert property (@(posedge clk) disable iff (rst)
        (state == GS_LOCK) |=> (state == GS_LOCK));

    // R12: nothing moves while locked
    p_lock_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (state == GS_LOCK) |=> ($stable(tool_mode) && $stable(dbg_req) &&
            $stable(baud_sel) && $stable(wide_volt) && !tx_valid && !granted));

    // R10: a granted session stays granted
    p_grant_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        granted |=> granted);

    // R9: a debug session is granted only when debug was permitted
    p_grant_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(granted) && dbg_req) |-> $past(dbg_enable));

    // R2: tool_mode only ever holds a defined code
    p_tool_code_r2: assert property (@(posedge clk) disable iff (rst)
        (tool_mode == 8'h00 || tool_mode == 8'h3A || tool_mode == 8'h35));
endmodule

bind serial_entry_gate serial_entry_gate_chk #(.BAUD_W(BAUD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (state_q),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tool_mode  (tool_mode),
    .dbg_req    (dbg_req),
    .baud_sel   (baud_sel),
    .wide_volt  (wide_volt),
    .granted    (granted),
    .dbg_enable (dbg_enable)
);

// File: tb/tb_serial_entry_gate.sv
module tb_serial_entry_gate;
    localparam int BAUD_W = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        rx_data = 8'h00;
    logic              rx_valid = 1'b0;
    logic [7:0]        tx_data;
    logic              tx_valid;
    logic              tx_ready = 1'b0;
    logic              dbg_enable = 1'b0;
    logic              low_speed = 1'b0;
    logic [7:0]        tool_mode;
    logic              dbg_req;
    logic [BAUD_W-1:0] baud_sel;
    logic              wide_volt;
    logic              granted;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    serial_entry_gate #(.BAUD_W(BAUD_W), .BAUD_LIMIT(4), .VOLT_MIN(18)) dut (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .dbg_enable(dbg_enable), .low_speed(low_speed),
        .tool_mode(tool_mode), .dbg_req(dbg_req), .baud_sel(baud_sel),
        .wide_volt(wide_volt), .granted(granted)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx_valid = 1'b0;
        tx_ready = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic check_frozen(input int t, input int d, input int bs, input int w, input string req);
        chk({req, " tool_mode"}, tool_mode, t);
        chk({req, " dbg_req"}, dbg_req, d);
        chk({req, " baud_sel"}, baud_sel, bs);
        chk({req, " wide_volt"}, wide_volt, w);
        chk({req, " tx_valid"}, tx_valid, 0);
        chk({req, " granted"}, granted, 0);
    endtask

    task automatic run_case(input logic [7:0] first, input logic [7:0] cmd,
                            input int baud, input int volt, input logic en,
                            input logic ls, input int stall);
        int exp_tool;
        int exp_dbg;
        int exp_baud;
        int exp_wide;
        int exp_code;
        dbg_enable = en;
        low_speed  = ls;
        do_reset();
        exp_tool = (first == 8'h3A) ? 8'h3A : (first == 8'h00) ? 8'h35 : 8'h00;
        exp_dbg  = (first == 8'hC5) ? 1 : 0;
        exp_baud = 0;
        exp_wide = 0;
        exp_code = 0;
        if (cmd != 8'h9A) exp_code = 8'h04;
        else if (baud >= 4) exp_code = 8'h05;
        else begin
            exp_baud = baud;
            if (volt < 18) exp_code = 8'h05;
            else begin
                exp_wide = ls;
                if (exp_dbg == 1 && !en) exp_code = 8'h10;
            end
        end
        send(first);
        send(cmd);
        send(8'(baud));
        send(8'(volt));
        chk("R2 R3 R4 tool_mode", tool_mode, exp_tool);
        chk("R4 R9 dbg_req", dbg_req, exp_dbg);
        chk("R7 baud_sel", baud_sel, exp_baud);
        chk("R8 R13 wide_volt", wide_volt, exp_wide);
        if (exp_code != 0) begin
            for (int k = 0; k < stall; k++) begin
                chk("R11 tx_valid held", tx_valid, 1);
                chk("R6 R7 R8 R9 tx_data", tx_data, exp_code);
                chk("R10 no grant on reject", granted, 0);
                tick();
            end
            chk("R11 tx_valid offered", tx_valid, 1);
            chk("R6 R7 R8 R9 tx_data", tx_data, exp_code);
            tx_ready = 1'b1;
            tick();
            tx_ready = 1'b0;
            chk("R11 tx_valid drops", tx_valid, 0);
            send(8'h3A);
            send(8'h9A);
            check_frozen(exp_tool, exp_dbg, exp_baud, exp_wide, "R12");
        end else begin
            chk("R10 granted", granted, 1);
            chk("R10 no reply", tx_valid, 0);
            send(8'h00);
            chk("R10 granted sticky", granted, 1);
        end
    endtask

    initial begin
        logic [7:0] firsts [3];
        logic [7:0] cmds [2];
        int volts [4];
        int idx;
        firsts[0] = 8'h3A; firsts[1] = 8'h00; firsts[2] = 8'hC5;
        cmds[0] = 8'h9A; cmds[1] = 8'h9B;
        volts[0] = 17; volts[1] = 18; volts[2] = 0; volts[3] = 40;

        do_reset();
        chk("R1 tool_mode", tool_mode, 0);
        chk("R1 dbg_req", dbg_req, 0);
        chk("R1 baud_sel", baud_sel, 0);
        chk("R1 wide_volt", wide_volt, 0);
        chk("R1 granted", granted, 0);
        chk("R1 tx_valid", tx_valid, 0);

        // sweep every first byte
        for (int b = 0; b < 256; b++) begin
            do_reset();
            send(8'(b));
            if (b == 8'h3A) begin
                chk("R2 tool_mode", tool_mode, 8'h3A);
                chk("R2 dbg_req", dbg_req, 0);
            end else if (b == 8'h00) begin
                chk("R3 tool_mode", tool_mode, 8'h35);
                chk("R3 dbg_req", dbg_req, 0);
            end else if (b == 8'hC5) begin
                chk("R4 tool_mode", tool_mode, 8'h00);
                chk("R4 dbg_req", dbg_req, 1);
            end else begin
                chk("R5 no reply", tx_valid, 0);
                send(8'hC5);
                send(8'h9A);
                send(8'h01);
                send(8'd33);
                check_frozen(0, 0, 0, 0, "R5");
            end
        end

        // setup frame sweep
        idx = 0;
        for (int f = 0; f < 3; f++)
            for (int c = 0; c < 2; c++)
                for (int bd = 0; bd < 6; bd++)
                    for (int v = 0; v < 4; v++)
                        for (int e = 0; e < 2; e++)
                            for (int l = 0; l < 2; l++) begin
                                run_case(firsts[f], cmds[c], bd, volts[v],
                                         1'(e), 1'(l), idx % 3);
                                idx++;
                            end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule